// File: doc/BRIEF.md
# Reprogrammable Two-Digit Combination Lock

This block guards a door with a secret code of two digits, each two bits wide. A user sets a digit value and presses Enter to submit it. Two correct digits in the right order unlock the door. While the door is unlocked, the user can replace the code with a new one through two programming steps. The design is a Moore state machine, so the Open flag, the status code and the displayed code all come from registered state only.

Digits are read only on an Enter pulse. A wrong first digit does not reveal itself at once. The machine still takes a second digit, and it reports the error only after that second Enter. A restore pulse loads the factory code, first digit 3 and second digit 1, and returns the machine to the locked state. Synchronous reset also returns the machine to the locked state but keeps the stored code unchanged. The current code is always available on the outputs for display.

Top module: `combo_lock`

## Requirements
- R1: When `rst` is high at a rising edge, the machine goes to the locked state (status 0, `open_o`=0) and the stored code keeps its value.
- R2: When `restore_i` is high at a rising edge without reset, the stored code becomes first=2'b11 and second=2'b01, and the status becomes 0. This holds even if `enter_i` is high in the same cycle, because restore takes priority.
- R3: A rising edge with `enter_i` and `restore_i` both low changes neither the status nor the stored code, whatever `digit_i` holds.
- R4: From status 0, an Enter with the stored first digit moves to status 1. A following Enter with the stored second digit moves to status 2 with `open_o`=1.
- R5: From status 0, an Enter with a wrong first digit moves to status 1 and does not move to status 5. The next Enter moves to status 5 whatever its digit is.
- R6: From status 1 after a correct first digit, an Enter with a wrong second digit moves to status 5.
- R7: From status 2, Enter moves to status 3. From status 3, Enter stores `digit_i` as the new first digit and moves to status 4. From status 4, Enter stores `digit_i` as the new second digit and returns to status 2.
- R8: After programming, only the new code opens the lock. The old code leads to status 5.
- R9: From status 5, Enter moves to status 0, and the digit given on that press is discarded.
- R10: The status encoding is 0 = awaiting first digit, 1 = awaiting second digit, 2 = open, 3 = program first digit, 4 = program second digit, 5 = error. `open_o` is 1 exactly when the status is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All registers update on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. It affects the state only, not the code. |
| restore_i | input | 1 | Single-cycle pulse that loads the factory code and locks the door. |
| enter_i | input | 1 | Single-cycle Enter pulse that submits `digit_i`. |
| digit_i | input | 2 | Digit value that is sampled on Enter. |
| open_o | output | 1 | Door unlocked. |
| status_o | output | 3 | Status code, encoded as in R10. |
| code_first_o | output | 2 | Stored first digit, for display. |
| code_second_o | output | 2 | Stored second digit, for display. |

## Verification
The assertions assume that Enter and restore are pulses of one cycle that are sampled at rising edges. They also assume that the stored code holds a known value before any property reads it, which means restore has been pulsed once since power-up. The bench meets these assumptions. It pulses restore before its first check, raises each input at a falling edge for exactly one cycle, and leaves a quiet cycle between actions. It changes `digit_i` only on cycles without Enter, or together with Enter for that single press.

// File: rtl/ckl_pkg.sv
package ckl_pkg;

    localparam int DIGIT_W  = 2;
    localparam int STATUS_W = 3;

    typedef logic [DIGIT_W-1:0]  digit_t;
    typedef logic [STATUS_W-1:0] status_t;

    typedef struct packed {
        digit_t first;
        digit_t second;
    } code_t;

    typedef enum logic [2:0] {
        ST_WAIT1   = 3'd0,
        ST_WAIT2OK = 3'd1,
        ST_WAIT2NG = 3'd2,
        ST_UNLOCK  = 3'd3,
        ST_PGM1    = 3'd4,
        ST_PGM2    = 3'd5,
        ST_FAULT   = 3'd6
    } state_t;

    localparam status_t STS_LOCKED = 3'd0;
    localparam status_t STS_SECOND = 3'd1;
    localparam status_t STS_OPEN   = 3'd2;
    localparam status_t STS_PGM1   = 3'd3;
    localparam status_t STS_PGM2   = 3'd4;
    localparam status_t STS_ERROR  = 3'd5;

    function automatic status_t status_of(state_t s);
        case (s)
            ST_WAIT1:   return STS_LOCKED;
            ST_WAIT2OK: return STS_SECOND;
            ST_WAIT2NG: return STS_SECOND;
            ST_UNLOCK:  return STS_OPEN;
            ST_PGM1:    return STS_PGM1;
            ST_PGM2:    return STS_PGM2;
            ST_FAULT:   return STS_ERROR;
            default:    return STS_LOCKED;
        endcase
    endfunction

endpackage

// File: rtl/ckl_code_store.sv
module ckl_code_store
    import ckl_pkg::*;
#(
    parameter digit_t DEF_FIRST  = 2'b11,
    parameter digit_t DEF_SECOND = 2'b01
) (
    input  logic   clk,
    input  logic   load_default,
    input  logic   wr_first,
    input  logic   wr_second,
    input  digit_t wr_digit,
    output code_t  code
);

    code_t code_q;

    // No reset: the code survives a synchronous reset.
    always_ff @(posedge clk) begin
        if (load_default) begin
            code_q.first  <= DEF_FIRST;
            code_q.second <= DEF_SECOND;
        end else begin
            if (wr_first)  code_q.first  <= wr_digit;
            if (wr_second) code_q.second <= wr_digit;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/ckl_fsm.sv
module ckl_fsm
    import ckl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restore,
    input  logic   enter,
    input  digit_t digit,
    input  code_t  code,
    output state_t state,
    output logic   wr_first,
    output logic   wr_second
);

    state_t state_q, state_d;
    logic   act;

    assign act = enter && !restore && !rst;

    always_ff @(posedge clk) begin
        if (rst || restore) state_q <= ST_WAIT1;
        else                state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (enter) begin
            case (state_q)
                ST_WAIT1:   state_d = (digit == code.first)  ? ST_WAIT2OK : ST_WAIT2NG;
                ST_WAIT2OK: state_d = (digit == code.second) ? ST_UNLOCK  : ST_FAULT;
                ST_WAIT2NG: state_d = ST_FAULT;
                ST_UNLOCK:  state_d = ST_PGM1;
                ST_PGM1:    state_d = ST_PGM2;
                ST_PGM2:    state_d = ST_UNLOCK;
                ST_FAULT:   state_d = ST_WAIT1;
                default:    state_d = ST_WAIT1;
            endcase
        end
    end

    assign wr_first  = act && (state_q == ST_PGM1);
    assign wr_second = act && (state_q == ST_PGM2);
    assign state     = state_q;

endmodule

// File: rtl/ckl_status_dec.sv
module ckl_status_dec
    import ckl_pkg::*;
(
    input  state_t  state,
    output status_t status,
    output logic    open
);

    assign status = status_of(state);
    assign open   = (state == ST_UNLOCK);

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import ckl_pkg::*;
#(
    parameter digit_t DEF_FIRST  = 2'b11,
    parameter digit_t DEF_SECOND = 2'b01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restore_i,
    input  logic                enter_i,
    input  logic [DIGIT_W-1:0]  digit_i,
    output logic                open_o,
    output logic [STATUS_W-1:0] status_o,
    output logic [DIGIT_W-1:0]  code_first_o,
    output logic [DIGIT_W-1:0]  code_second_o
);

    code_t  code;
    state_t state;
    logic   wr_first, wr_second;

    ckl_code_store #(.DEF_FIRST(DEF_FIRST), .DEF_SECOND(DEF_SECOND)) u_store (
        .clk          (clk),
        .load_default (restore_i && !rst),
        .wr_first     (wr_first),
        .wr_second    (wr_second),
        .wr_digit     (digit_i),
        .code         (code)
    );

    ckl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .restore   (restore_i),
        .enter     (enter_i),
        .digit     (digit_i),
        .code      (code),
        .state     (state),
        .wr_first  (wr_first),
        .wr_second (wr_second)
    );

    ckl_status_dec u_dec (
        .state  (state),
        .status (status_o),
        .open   (open_o)
    );

    assign code_first_o  = code.first;
    assign code_second_o = code.second;

endmodule

// File: rtl/ckl_checker.sv
module ckl_checker
    import ckl_pkg::*;
#(
    parameter digit_t DEF_FIRST  = 2'b11,
    parameter digit_t DEF_SECOND = 2'b01
) (
    input logic    clk,
    input logic    rst,
    input logic    restore_i,
    input logic    enter_i,
    input digit_t  digit_i,
    input logic    open_o,
    input status_t status_o,
    input digit_t  code_first_o,
    input digit_t  code_second_o
);

    logic go;
    assign go = enter_i && !restore_i;

    assert_reset_locks_R1: assert property (@(posedge clk)
        rst |=> (status_o == STS_LOCKED) && !open_o);

    assert_reset_keeps_code_R1: assert property (@(posedge clk)
        rst && !restore_i |=> $stable(code_first_o) && $stable(code_second_o));

    assert_restore_default_R2: assert property (@(posedge clk) disable iff (rst)
        restore_i |=> code_first_o == DEF_FIRST && code_second_o == DEF_SECOND
                      && status_o == STS_LOCKED);

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !enter_i && !restore_i |=> $stable(status_o) && $stable(code_first_o)
                                   && $stable(code_second_o));

    assert_first_never_errors_R5: assert property (@(posedge clk) disable iff (rst)
        go && status_o == STS_LOCKED |=> status_o == STS_SECOND);

    assert_open_to_pgm_R7: assert property (@(posedge clk) disable iff (rst)
        go && status_o == STS_OPEN |=> status_o == STS_PGM1);

    assert_pgm2_stores_R7: assert property (@(posedge clk) disable iff (rst)
        go && status_o == STS_PGM2 |=> status_o == STS_OPEN
                                       && code_second_o == $past(digit_i));

    assert_error_clears_R9: assert property (@(posedge clk) disable iff (rst)
        go && status_o == STS_ERROR |=> status_o == STS_LOCKED);

    always_comb begin
        assert_open_flag_R10: assert (open_o == (status_o == STS_OPEN));
        assert_status_range_R10: assert (status_o <= STS_ERROR);
    end

endmodule

bind combo_lock ckl_checker #(.DEF_FIRST(DEF_FIRST), .DEF_SECOND(DEF_SECOND)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .restore_i     (restore_i),
    .enter_i       (enter_i),
    .digit_i       (digit_i),
    .open_o        (open_o),
    .status_o      (status_o),
    .code_first_o  (code_first_o),
    .code_second_o (code_second_o)
);

// File: tb/combo_lock_test.sv
module combo_lock_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restore_i = 1'b0;
    logic       enter_i = 1'b0;
    logic [1:0] digit_i = 2'b00;
    logic       open_o;
    logic [2:0] status_o;
    logic [1:0] code_first_o, code_second_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] st;
        logic [1:0] f;
        logic [1:0] s;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    combo_lock uut (
        .clk           (clk),
        .rst           (rst),
        .restore_i     (restore_i),
        .enter_i       (enter_i),
        .digit_i       (digit_i),
        .open_o        (open_o),
        .status_o      (status_o),
        .code_first_o  (code_first_o),
        .code_second_o (code_second_o)
    );

    // One action of one cycle, followed by a quiet cycle
    task automatic act(input bit r, input bit rs, input bit en, input logic [1:0] d,
                       input logic [2:0] st, input logic [1:0] f, input logic [1:0] s,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; restore_i = rs; enter_i = en; digit_i = d;
        e.st = st; e.f = f; e.s = s; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        rst = 1'b0; restore_i = 1'b0; enter_i = 1'b0;
    endtask

    // Monitor: compares the outputs just after the edge that acted
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic exp_open;
                e = q.pop_front();
                exp_open = (e.st == 3'd2);
                compared++;
                if (status_o !== e.st || open_o !== exp_open ||
                    code_first_o !== e.f || code_second_o !== e.s) begin
                    mismatched++;
                    $display("FAIL %s: got st=%0d open=%0b code=%b,%b expected st=%0d open=%0b code=%b,%b",
                             e.tag, status_o, open_o, code_first_o, code_second_o,
                             e.st, exp_open, e.f, e.s);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        act(0, 1, 0, 2'b00, 3'd0, 2'b11, 2'b01, "R2 restore default");
        act(0, 0, 0, 2'b10, 3'd0, 2'b11, 2'b01, "R3 idle while locked");
        act(0, 0, 1, 2'b11, 3'd1, 2'b11, 2'b01, "R4 first digit ok");
        act(0, 0, 0, 2'b00, 3'd1, 2'b11, 2'b01, "R3 idle while waiting");
        act(0, 0, 1, 2'b01, 3'd2, 2'b11, 2'b01, "R4 opens R10");
        act(0, 0, 1, 2'b10, 3'd3, 2'b11, 2'b01, "R7 enter program");
        act(0, 0, 1, 2'b00, 3'd4, 2'b00, 2'b01, "R7 store first");
        act(0, 0, 0, 2'b11, 3'd4, 2'b00, 2'b01, "R3 idle while programming");
        act(0, 0, 1, 2'b10, 3'd2, 2'b00, 2'b10, "R7 store second");
        act(1, 0, 0, 2'b00, 3'd0, 2'b00, 2'b10, "R1 reset keeps code");
        act(0, 0, 1, 2'b11, 3'd1, 2'b00, 2'b10, "R5 wrong first no error");
        act(0, 0, 1, 2'b01, 3'd5, 2'b00, 2'b10, "R8 old code rejected R5");
        act(0, 0, 0, 2'b00, 3'd5, 2'b00, 2'b10, "R3 idle in error");
        act(0, 0, 1, 2'b00, 3'd0, 2'b00, 2'b10, "R9 error clears");
        act(0, 0, 1, 2'b10, 3'd1, 2'b00, 2'b10, "R9 digit discarded");
        act(0, 0, 1, 2'b10, 3'd5, 2'b00, 2'b10, "R5 error after second");
        act(0, 0, 1, 2'b11, 3'd0, 2'b00, 2'b10, "R9 error clears again");
        act(0, 0, 1, 2'b00, 3'd1, 2'b00, 2'b10, "R8 new first");
        act(0, 0, 1, 2'b10, 3'd2, 2'b00, 2'b10, "R8 new code opens");
        act(1, 0, 0, 2'b00, 3'd0, 2'b00, 2'b10, "R1 reset from open");
        act(0, 0, 1, 2'b00, 3'd1, 2'b00, 2'b10, "R6 first ok");
        act(0, 0, 1, 2'b11, 3'd5, 2'b00, 2'b10, "R6 wrong second");
        act(0, 1, 1, 2'b00, 3'd0, 2'b11, 2'b01, "R2 restore beats enter");
        act(0, 0, 1, 2'b11, 3'd1, 2'b11, 2'b01, "R2 default first");
        act(0, 0, 1, 2'b01, 3'd2, 2'b11, 2'b01, "R2 default opens");
        act(0, 1, 0, 2'b00, 3'd0, 2'b11, 2'b01, "R2 restore from open R10");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule